// File: doc/BRIEF.md
# External Reference Second-Tick Synchronizer

This block produces the one-second timekeeping tick for a real-time clock. Normally the tick comes from a local prescaler that counts sub-second pulses from the crystal oscillator. When external synchronization is switched on, a reference signal arriving on a pin is brought into the system clock domain, its rising edges are divided down to a once-per-second event, and that event realigns the local prescaler. The second tick then follows the reference in frequency, while the local prescaler still fills in if a reference second comes late.

The reference may be a 1 Hz pulse-per-second signal, 50 Hz or 60 Hz mains, or a 32.768 kHz clock. A two-bit field selects the divisor. A watchdog notes when external seconds stop arriving. It raises a sticky loss-of-reference flag and drops back to the free-running local prescaler. No second is skipped and none is repeated during the switch. Software clears the flag with a one-cycle clear pulse once the reference is good again. All pins are plain level or pulse controls: the block has no data stream and no handshake.

Top module: `ext_ref_sync`

## Requirements
- R1: During and directly after reset, `sec_tick` and `los_flag` are both 0.
- R2: With `osc_en`=1 and `ext_en`=0, `sec_tick` pulses once every `LOCAL_DIV` pulses of `osc_sub_tick`, and activity on `ref_pin` has no effect on the tick.
- R3: With `osc_en`=0 no tick is produced and the prescaler is held at zero. After re-enable, the first tick comes after a full `LOCAL_DIV` sub-pulses.
- R4: `rate_sel` picks the number of synchronized rising edges of `ref_pin` per external second: 2'b00 = `DIV_1HZ` (1), 2'b01 = `DIV_50HZ` (50), 2'b10 = `DIV_60HZ` (60), 2'b11 = `DIV_32K` (32768).
- R5: While locked (`ext_en`=1, `osc_en`=1, `los_flag`=0), an external second that arrives when the prescaler is at or past half of `LOCAL_DIV` emits `sec_tick` and restarts the prescaler. The tick is visible on the third rising clock edge after `ref_pin` rises (two synchronizer stages plus one output register).
- R6: While locked, an external second that arrives while the prescaler is below half restarts the prescaler and emits no tick, because the local wrap already produced that second.
- R7: With `ext_en`=1 and `osc_en`=1, `los_flag` rises on the second consecutive local prescaler wrap that had no external second in between. It never rises while either enable is 0.
- R8: `los_flag` stays set until a `los_clr` pulse clears it. Synchronization then resumes with the next external second.
- R9: When the reference stops, ticks continue at the local rate with each interval close to one local second, with no gap and no extra tick.
- R10: While `los_flag` is set, external seconds do not realign the prescaler.
- R11: `sec_tick` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pin | input | 1 | External reference, asynchronous to clk |
| osc_sub_tick | input | 1 | One-cycle pulse per local oscillator sub-second step |
| osc_en | input | 1 | Local oscillator running; 0 stops timekeeping |
| ext_en | input | 1 | Enable synchronization to the external reference |
| rate_sel | input | 2 | Reference rate select (see R4) |
| los_clr | input | 1 | One-cycle pulse that clears the loss flag |
| sec_tick | output | 1 | One-cycle pulse per second |
| los_flag | output | 1 | Sticky loss-of-reference flag |

## Verification
The properties assume that `osc_sub_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `LOCAL_DIV` is at least 2, so that two tick sources can never fire on back-to-back cycles. The reference must hold each level for at least two clock cycles, or the synchronizer may miss edges. The bench drives one sub-pulse every fourth cycle, keeps every `ref_pin` level at least three cycles, and issues `los_clr` only as a single-cycle pulse. This keeps every scenario within those limits.

// File: rtl/ext_ref_pkg.sv
package ext_ref_pkg;

  typedef enum logic [1:0] {
    RATE_PPS  = 2'b00,
    RATE_50HZ = 2'b01,
    RATE_60HZ = 2'b10,
    RATE_32K  = 2'b11
  } rate_sel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ers_pin_sync.sv
module ers_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ers_ref_divider.sv
module ers_ref_divider
  import ext_ref_pkg::*;
#(
  parameter int unsigned DIV_1HZ  = 1,
  parameter int unsigned DIV_50HZ = 50,
  parameter int unsigned DIV_60HZ = 60,
  parameter int unsigned DIV_32K  = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate_sel,
  input  logic       ref_rise,
  output logic       ext_tick
);
  localparam int unsigned MAXD = max4(DIV_1HZ, DIV_50HZ, DIV_60HZ, DIV_32K);
  localparam int unsigned CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          at_last;

  always_comb begin
    unique case (rate_sel_e'(rate_sel))
      RATE_PPS:  last = CW'(DIV_1HZ - 1);
      RATE_50HZ: last = CW'(DIV_50HZ - 1);
      RATE_60HZ: last = CW'(DIV_60HZ - 1);
      default:   last = CW'(DIV_32K - 1);
    endcase
  end

  assign at_last  = (cnt >= last);
  assign ext_tick = en & ref_rise & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
    end else if (ref_rise) begin
      if (at_last) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ers_prescaler.sv
module ers_prescaler #(
  parameter int unsigned LOCAL_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sub_tick,
  input  logic locked,
  input  logic ext_tick,
  output logic tick,
  output logic wrap
);
  localparam int unsigned PW   = (LOCAL_DIV > 2) ? $clog2(LOCAL_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(LOCAL_DIV - 1);
  localparam logic [PW-1:0] HALF = PW'(LOCAL_DIV / 2);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
      wrap <= 1'b0;
    end else begin
      tick <= 1'b0;
      wrap <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (locked && ext_tick) begin
        cnt  <= '0;
        tick <= (cnt >= HALF);
      end else if (sub_tick) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
          wrap <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ers_los_monitor.sv
module ers_los_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic local_wrap,
  input  logic ext_tick,
  input  logic clr,
  output logic los
);
  logic [1:0] miss;
  logic       set_now;

  assign set_now = en & local_wrap & ~ext_tick & (miss != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      miss <= 2'd0;
    end else if (ext_tick || clr) begin
      miss <= 2'd0;
    end else if (local_wrap && miss != 2'd2) begin
      miss <= miss + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       los <= 1'b0;
    else if (set_now) los <= 1'b1;
    else if (clr)     los <= 1'b0;
  end
endmodule

// File: rtl/ext_ref_sync.sv
module ext_ref_sync #(
  parameter int unsigned LOCAL_DIV   = 32768,
  parameter int unsigned DIV_1HZ     = 1,
  parameter int unsigned DIV_50HZ    = 50,
  parameter int unsigned DIV_60HZ    = 60,
  parameter int unsigned DIV_32K     = 32768,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pin,
  input  logic       osc_sub_tick,
  input  logic       osc_en,
  input  logic       ext_en,
  input  logic [1:0] rate_sel,
  input  logic       los_clr,
  output logic       sec_tick,
  output logic       los_flag
);
  logic ref_rise;
  logic ext_tick;
  logic local_wrap;
  logic sync_en;
  logic locked;

  assign sync_en = ext_en & osc_en;
  assign locked  = sync_en & ~los_flag;

  ers_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ref_pin),
    .rise (ref_rise)
  );

  ers_ref_divider #(
    .DIV_1HZ (DIV_1HZ),
    .DIV_50HZ(DIV_50HZ),
    .DIV_60HZ(DIV_60HZ),
    .DIV_32K (DIV_32K)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sync_en),
    .rate_sel(rate_sel),
    .ref_rise(ref_rise),
    .ext_tick(ext_tick)
  );

  ers_prescaler #(.LOCAL_DIV(LOCAL_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (osc_en),
    .sub_tick(osc_sub_tick),
    .locked  (locked),
    .ext_tick(ext_tick),
    .tick    (sec_tick),
    .wrap    (local_wrap)
  );

  ers_los_monitor u_los (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (sync_en),
    .local_wrap(local_wrap),
    .ext_tick  (ext_tick),
    .clr       (los_clr),
    .los       (los_flag)
  );
endmodule

// File: rtl/ext_ref_sync_chk.sv
module ext_ref_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic ext_en,
  input logic los_clr,
  input logic sec_tick,
  input logic los_flag
);
  p_tick_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  p_no_tick_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !sec_tick);

  p_los_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_flag) |-> $past(ext_en && osc_en));

  p_los_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (los_flag && !los_clr) |=> los_flag);

  p_los_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (los_clr && !ext_en) |=> !los_flag);
endmodule

bind ext_ref_sync ext_ref_sync_chk u_chk (.*);

// File: tb/ext_ref_sync_bench.sv
module ext_ref_sync_bench;
  localparam int LDIV = 16;
  localparam int SUBP = 4;
  localparam int SEC  = LDIV * SUBP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pin = 1'b0;
  logic osc_sub_tick = 1'b0;
  logic osc_en = 1'b0;
  logic ext_en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic los_clr = 1'b0;
  logic sec_tick;
  logic los_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ref_period = 0;
  int last_rise = 0;
  int tick_count = 0;
  int last_tick = 0;
  int prev_tick = 0;
  int double_pulse = 0;
  int los_rise_cyc = 0;
  bit was_high = 0;
  bit los_prev = 0;
  bit done = 0;

  ext_ref_sync #(
    .LOCAL_DIV(LDIV), .DIV_1HZ(1), .DIV_50HZ(5), .DIV_60HZ(6), .DIV_32K(8)
  ) u_ext_ref_sync (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : sub_gen
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      k = k + 1;
      osc_sub_tick = (k % SUBP == 0);
    end
  end

  initial begin : ref_gen
    forever begin
      if (ref_period == 0) begin
        ref_pin = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = ref_period;
        ref_pin = 1'b1;
        last_rise = cyc;
        repeat (p / 2) @(negedge clk);
        ref_pin = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (sec_tick) begin
      tick_count <= tick_count + 1;
      prev_tick  <= last_tick;
      last_tick  <= cyc;
    end
    if (sec_tick && was_high) double_pulse <= double_pulse + 1;
    was_high <= sec_tick;
    if (los_flag && !los_prev) los_rise_cyc <= cyc;
    los_prev <= los_flag;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    int c;
    c = tick_count;
    while (tick_count == c) step();
  endtask

  task automatic interval(output int iv);
    wait_tick();
    wait_tick();
    iv = last_tick - prev_tick;
  endtask

  task automatic t_reset();
    chk(sec_tick == 1'b0, "R1 tick in reset", sec_tick, 0);
    chk(los_flag == 1'b0, "R1 los in reset", los_flag, 0);
    rst_n = 1'b1;
    step();
    chk(sec_tick == 1'b0 && los_flag == 1'b0, "R1 after reset", {sec_tick, los_flag}, 0);
  endtask

  task automatic t_local();
    int iv;
    int c0;
    osc_en = 1'b1;
    ext_en = 1'b0;
    ref_period = 48;
    wait_tick();
    interval(iv);
    chk(iv == SEC, "R2 local interval, ref ignored", iv, SEC);
    c0 = tick_count;
    repeat (10 * SEC) step();
    chk(tick_count - c0 == 10, "R2 ticks per window", tick_count - c0, 10);
    chk(double_pulse == 0, "R11 single-cycle pulse", double_pulse, 0);
  endtask

  task automatic t_off();
    int c0;
    osc_en = 1'b0;
    step();
    c0 = tick_count;
    repeat (300) step();
    chk(tick_count == c0, "R3 no tick when off", tick_count - c0, 0);
    osc_en = 1'b1;
    repeat (56) step();
    chk(tick_count == c0, "R3 prescaler restarted", tick_count - c0, 0);
    repeat (16) step();
    chk(tick_count == c0 + 1, "R3 first tick after full second", tick_count - c0, 1);
  endtask

  task automatic t_rate(input logic [1:0] sel, input int per, input int div, input string req);
    int iv;
    rate_sel = sel;
    ref_period = per;
    ext_en = 1'b1;
    wait_tick();
    wait_tick();
    interval(iv);
    chk(iv == per * div, req, iv, per * div);
    chk(los_flag == 1'b0, "R4 no loss while fed", los_flag, 0);
  endtask

  task automatic t_align();
    rate_sel = 2'b00;
    ref_period = 48;
    wait_tick();
    wait_tick();
    chk(last_tick - last_rise == 3, "R5 tick latency from ref rise", last_tick - last_rise, 3);
  endtask

  task automatic t_slow();
    int iv;
    int c0;
    ref_period = 72;
    wait_tick();
    wait_tick();
    interval(iv);
    chk(iv == 72, "R6 realign without extra tick", iv, 72);
    c0 = tick_count;
    repeat (720) step();
    chk(tick_count - c0 == 10, "R6 one tick per ref second", tick_count - c0, 10);
    chk(los_flag == 1'b0, "R6 late ref is not loss", los_flag, 0);
  endtask

  task automatic t_loss();
    int iv;
    int d;
    ref_period = 48;
    wait_tick();
    wait_tick();
    ref_period = 0;
    for (int i = 0; i < 3; i++) begin
      wait_tick();
      iv = last_tick - prev_tick;
      chk(iv >= SEC - 4 && iv <= SEC + 4, "R9 fallback interval", iv, SEC);
    end
    chk(los_flag == 1'b1, "R7 loss flagged", los_flag, 1);
    d = los_rise_cyc - last_rise;
    chk(d >= 2 * SEC - 8 && d <= 2 * SEC + 12, "R7 loss after two wraps", d, 2 * SEC);
  endtask

  task automatic t_unlocked();
    int iv;
    ref_period = 48;
    wait_tick();
    interval(iv);
    chk(iv == SEC, "R10 no realign while lost", iv, SEC);
    chk(los_flag == 1'b1, "R8 flag sticky", los_flag, 1);
  endtask

  task automatic t_clear();
    int iv;
    los_clr = 1'b1;
    step();
    los_clr = 1'b0;
    step();
    chk(los_flag == 1'b0, "R8 cleared by pulse", los_flag, 0);
    wait_tick();
    wait_tick();
    interval(iv);
    chk(iv == 48, "R8 relock after clear", iv, 48);
    chk(double_pulse == 0, "R11 no stretched pulse", double_pulse, 0);
  endtask

  task automatic t_ext_off_no_los();
    ext_en = 1'b0;
    ref_period = 0;
    repeat (4 * SEC) step();
    chk(los_flag == 1'b0, "R7 no loss with sync off", los_flag, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) step();
    t_reset();
    t_local();
    t_off();
    t_rate(2'b00, 48, 1, "R4 sel 00 divide");
    t_rate(2'b01, 10, 5, "R4 sel 01 divide");
    t_rate(2'b10, 8, 6, "R4 sel 10 divide");
    t_rate(2'b11, 6, 8, "R4 sel 11 divide");
    t_align();
    t_slow();
    t_loss();
    t_unlocked();
    t_clear();
    t_ext_off_no_los();
    finish_run();
  end
endmodule